// File: doc/BRIEF.md
# Transport System Time Counter

This block keeps a local transport time base in the same layout as a program clock reference sample. It runs directly on the system time clock, a nominal 27 MHz input from an external voltage-controlled crystal oscillator. The low part is a 9-bit extension that counts modulo 300. The high part is a 33-bit base that advances once per extension wrap. Together they form a 42-bit time value, with the base in the upper bits and the extension in the lower bits, so a captured time can be compared directly with a received clock reference.

A packet-arrival strobe may come from another clock domain. The block resynchronises it, detects its rising edge and takes one snapshot of the time into a timestamp register for each packet. A valid flag marks a fresh snapshot. An overrun flag marks a snapshot that replaced one nobody had read. Software can also read the live time and load the counter synchronously. All control inputs other than the strobe belong to the system time clock domain.

Top module: `stc_counter`

## Requirements
- R1: While rst_n is low, live_time, ts_time, ts_valid and ts_overrun are all zero.
- R2: live_time[8:0] (extension) rises by one on every clock edge without a load, counts 0 to 299 and never shows a value above 299.
- R3: On the edge where the extension goes from 299 to 0, live_time[41:9] (base) rises by one; on every other edge without a load the base holds.
- R4: A base of all ones wraps to zero when the extension wraps, with no flag.
- R5: load_en high at an edge replaces the increment and sets the base to load_base and the extension to load_ext, except that load_ext values 300 to 511 become 299.
- R6: A rising edge of pkt_strobe, held for at least one clock, copies into ts_time the live_time value seen after the second clock edge following it; the copy lands on the third edge, and ts_valid goes high on that edge.
- R7: Each rising edge of pkt_strobe gives exactly one capture, however long the strobe stays high.
- R8: ts_read high at an edge clears ts_valid, unless a capture happens on that same edge.
- R9: A capture while ts_valid is high and ts_read is low sets ts_overrun; ts_read high at an edge otherwise clears ts_overrun.
- R10: When a capture and a load fall on the same edge, ts_time receives the value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System time clock, nominal 27 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_strobe | input | 1 | Packet arrival strobe, asynchronous |
| load_en | input | 1 | Synchronous load of the counter |
| load_base | input | 33 | Base value to load |
| load_ext | input | 9 | Extension value to load (clamped to 299) |
| ts_read | input | 1 | Software read of the timestamp; clears the flags |
| live_time | output | 42 | Current time, {base, extension} |
| ts_time | output | 42 | Last captured time |
| ts_valid | output | 1 | Fresh snapshot not yet read |
| ts_overrun | output | 1 | Snapshot replaced before it was read |

## Verification
A load or an increment is visible on live_time one edge after the edge that takes it. A timestamp, with its flags, is visible three edges after the strobe rises. A read clears the flags one edge after it is seen. The bench drives inputs on the falling edge and keeps a reference model of time as a tick count, updated on the rising edge. At each following falling edge it compares every output with that model. Directed cases count these edges explicitly: they capture live_time after the second edge and check ts_time after the third.

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int BASE_W  = 33,
  parameter int EXT_W   = 9,
  parameter int EXT_MOD = 300
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pkt_strobe,
  input  logic                      load_en,
  input  logic [BASE_W-1:0]         load_base,
  input  logic [EXT_W-1:0]          load_ext,
  input  logic                      ts_read,
  output logic [BASE_W+EXT_W-1:0]   live_time,
  output logic [BASE_W+EXT_W-1:0]   ts_time,
  output logic                      ts_valid,
  output logic                      ts_overrun
);
  localparam int TIME_W = BASE_W + EXT_W;
  localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_MOD - 1);

  logic [BASE_W-1:0] base_q;
  logic [EXT_W-1:0]  ext_q;
  logic [2:0]        strb_q;
  logic              cap_pulse;
  logic [EXT_W-1:0]  ext_ld;

  assign ext_ld    = (load_ext > EXT_LAST) ? EXT_LAST : load_ext;
  assign cap_pulse = strb_q[1] & ~strb_q[2];
  assign live_time = {base_q, ext_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ext_q  <= '0;
    end else if (load_en) begin
      base_q <= load_base;
      ext_q  <= ext_ld;
    end else if (ext_q == EXT_LAST) begin
      base_q <= base_q + 1'b1;
      ext_q  <= '0;
    end else begin
      ext_q  <= ext_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= '0;
    else        strb_q <= {strb_q[1:0], pkt_strobe};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_time    <= '0;
      ts_valid   <= 1'b0;
      ts_overrun <= 1'b0;
    end else begin
      if (cap_pulse) ts_time <= live_time;

      if (cap_pulse)    ts_valid <= 1'b1;
      else if (ts_read) ts_valid <= 1'b0;

      if (cap_pulse && ts_valid && !ts_read) ts_overrun <= 1'b1;
      else if (ts_read)                      ts_overrun <= 1'b0;
    end
  end

  logic [TIME_W-1:0] unused_w;
  assign unused_w = '0;
endmodule

module stc_counter_chk #(
  parameter int BASE_W  = 33,
  parameter int EXT_W   = 9,
  parameter int EXT_MOD = 300
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load_en,
  input logic [EXT_W-1:0]        load_ext,
  input logic                    ts_read,
  input logic                    cap,
  input logic [BASE_W+EXT_W-1:0] live_time,
  input logic [BASE_W+EXT_W-1:0] ts_time,
  input logic                    ts_valid,
  input logic                    ts_overrun
);
  localparam logic [EXT_W-1:0] LAST = EXT_W'(EXT_MOD - 1);
  logic [EXT_W-1:0]  ext;
  logic [BASE_W-1:0] base;
  assign ext  = live_time[EXT_W-1:0];
  assign base = live_time[BASE_W+EXT_W-1:EXT_W];

  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ext <= LAST); // R2
  AST_EXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && ext != LAST) |=> (ext == EXT_W'($past(ext) + 1'b1)) && $stable(base)); // R3
  AST_EXT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && ext == LAST) |=> (ext == '0) && (base == BASE_W'($past(base) + 1'b1))); // R4
  AST_LOAD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_ext > LAST) |=> ext == LAST); // R5
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> ts_valid && (ts_time == $past(live_time))); // R6
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !cap); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_read && !cap) |=> !ts_valid && !ts_overrun); // R8
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && ts_valid && !ts_read) |=> ts_overrun); // R9
endmodule

bind stc_counter stc_counter_chk #(.BASE_W(BASE_W), .EXT_W(EXT_W), .EXT_MOD(EXT_MOD)) i_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_ext(load_ext), .ts_read(ts_read),
  .cap(cap_pulse), .live_time(live_time), .ts_time(ts_time), .ts_valid(ts_valid),
  .ts_overrun(ts_overrun));

// File: tb/test_stc_counter.sv
module test_stc_counter;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned MODV = 64'd300 << 33;

  logic clk = 1'b0, rst_n = 1'b0, pkt_strobe = 1'b0, load_en = 1'b0, ts_read = 1'b0;
  logic [32:0] load_base = '0;
  logic [8:0]  load_ext = '0;
  logic [41:0] live_time, ts_time;
  logic ts_valid, ts_overrun;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stc_counter i_stc_counter (.clk(clk), .rst_n(rst_n), .pkt_strobe(pkt_strobe), .load_en(load_en),
    .load_base(load_base), .load_ext(load_ext), .ts_read(ts_read), .live_time(live_time),
    .ts_time(ts_time), .ts_valid(ts_valid), .ts_overrun(ts_overrun));

  function automatic logic [41:0] pack(input longint unsigned t);
    pack = {33'(t / 300), 9'(t % 300)};
  endfunction

  function automatic longint unsigned ticks(input logic [32:0] b, input logic [8:0] e);
    longint unsigned ec = (e > 9'd299) ? 64'd299 : {55'd0, e};
    ticks = {31'd0, b} * 64'd300 + ec;
  endfunction

  // reference model: time as a tick count
  longint unsigned m;
  logic s1, s2, s3, ev, eo;
  logic [41:0] ets;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m <= 0; s1 <= 0; s2 <= 0; s3 <= 0; ets <= '0; ev <= 0; eo <= 0;
    end else begin
      m <= load_en ? ticks(load_base, load_ext) : (m + 1) % MODV;
      s1 <= pkt_strobe; s2 <= s1; s3 <= s2;
      if (s2 && !s3) begin ets <= pack(m); ev <= 1'b1; end
      else if (ts_read) ev <= 1'b0;
      if (s2 && !s3 && ev && !ts_read) eo <= 1'b1;
      else if (ts_read) eo <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [41:0] act, input logic [41:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R2/R3 live_time", live_time, pack(m));
    chk("R6 ts_time", ts_time, ets);
    chk("R8 ts_valid", {41'd0, ts_valid}, {41'd0, ev});
    chk("R9 ts_overrun", {41'd0, ts_overrun}, {41'd0, eo});
  endtask

  task automatic do_load(input logic [32:0] b, input logic [8:0] e);
    load_en = 1'b1; load_base = b; load_ext = e;
    step();
    load_en = 1'b0;
  endtask

  task automatic read_ts();
    ts_read = 1'b1; step(); ts_read = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [41:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 live", live_time, '0);
    chk("R1 ts", ts_time, '0);
    chk("R1 flags", {40'd0, ts_valid, ts_overrun}, '0);
    rst_n = 1'b1;
    repeat (310) step();
    chk("R3 base after one wrap", live_time, {33'd1, 9'd10});

    do_load(33'd5, 9'd298);
    chk("R5 load", live_time, {33'd5, 9'd298});
    step(); chk("R2 ext 299", live_time, {33'd5, 9'd299});
    step(); chk("R3 wrap carry", live_time, {33'd6, 9'd0});

    do_load({33{1'b1}}, 9'd299);
    step(); chk("R4 base wrap", live_time, 42'd0);

    do_load(33'd77, 9'd400); chk("R5 clamp 400", live_time, {33'd77, 9'd299});
    do_load(33'd78, 9'd511); chk("R5 clamp 511", live_time, {33'd78, 9'd299});
    do_load(33'd79, 9'd300); chk("R5 clamp 300", live_time, {33'd79, 9'd299});

    pkt_strobe = 1'b1;
    step(); step(); v = live_time; step();
    chk("R6 captured", ts_time, v);
    chk("R6 valid", {41'd0, ts_valid}, 42'd1);
    repeat (10) step();
    chk("R7 no recapture", ts_time, v);
    chk("R7 no overrun", {41'd0, ts_overrun}, 42'd0);
    pkt_strobe = 1'b0; step();
    read_ts();
    chk("R8 valid cleared", {41'd0, ts_valid}, 42'd0);

    pkt_strobe = 1'b1; step(); pkt_strobe = 1'b0; repeat (4) step();
    pkt_strobe = 1'b1; step(); pkt_strobe = 1'b0; repeat (4) step();
    chk("R9 overrun set", {41'd0, ts_overrun}, 42'd1);
    read_ts();
    chk("R9 overrun cleared", {40'd0, ts_valid, ts_overrun}, 42'd0);

    pkt_strobe = 1'b1;
    step(); step(); v = live_time;
    do_load(33'd1000, 9'd7);
    chk("R10 pre-load capture", ts_time, v);
    chk("R10 load applied", live_time, {33'd1000, 9'd7});
    pkt_strobe = 1'b0; step(); read_ts();

    for (int i = 0; i < 3000; i++) begin
      load_en   = ($urandom % 50) == 0;
      load_base = {$urandom, $urandom} >> 31;
      load_ext  = 9'($urandom % 512);
      ts_read   = ($urandom % 8) == 0;
      if (($urandom % 6) == 0) pkt_strobe = ~pkt_strobe;
      step();
    end
    load_en = 1'b0; ts_read = 1'b0;
    rst_n = 1'b0; @(negedge clk);
    chk("R1 reset again", live_time | ts_time, '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule